// File: doc/BRIEF.md
# Byte Rotate Execute Unit

This unit carries out two single-byte rotate instructions for an 8-bit microcontroller data path. The first rotates a byte left with no carry involved. The second rotates a byte right through the carry flag. The unit holds a banked byte-wide data file, a working register W, a bank pointer and the carry, negative and zero flags. A pulse on `start` hands the unit a 16-bit instruction word. The unit then steps through four phases: decode, operand read, compute and write-back. It signals completion with `done`. A word that is neither rotate raises `illegal` for one cycle, and no state changes.

The rest of the core uses a plain side port to place bytes in the data file. It uses a seed strobe to preset W, the bank pointer and carry. It reads any file byte through a combinational peek port. The side port and the seed strobe act only while the unit is idle.

Top module: `rot_exec_unit`

## Requirements
- R1: The word `0100_01da_ffff_ffff` (bits 15:10 = 010001) rotates left without carry. Result bit n+1 takes operand bit n, and result bit 0 takes operand bit 7. For example, 0xAB becomes 0x57.
- R2: A left rotate leaves carry unchanged. Both rotates set negative to result bit 7 and set zero when the result is 0x00.
- R3: The word `0011_00da_ffff_ffff` (bits 15:10 = 001100) rotates right through carry. The result is {old carry, operand[7:1]}, and carry becomes operand bit 0. For example, 0xE6 with carry 0 gives 0x73 and carry 0.
- R4: Bit 9 (d) picks the destination. With d = 0 the result goes to W and the file byte is unchanged. With d = 1 the result goes to the file byte and W is unchanged.
- R5: With bit 8 (a) = 1, the file address is {bank pointer, f}, where f is bits 7:0.
- R6: With a = 0 the bank pointer is ignored. An f below 0x80 addresses bank 0, and an f of 0x80 or above addresses the top bank (all ones).
- R7: After `start` is sampled in idle, the next four cycles are the four phases. `done` is high in exactly the fourth of them, which is the Q4 phase. The updated registers are visible in the cycle after it.
- R8: A word that matches neither encoding holds `illegal` high for exactly the first cycle after `start`. It gives no `done` and changes no register, flag or file byte.
- R9: `start` is ignored while an instruction is in flight, and the running instruction completes unaffected.
- R10: `extWe` writes `extData` to `extAddr`, and `seedEn` loads W, the bank pointer and carry. Both take effect only while the unit is idle. `peekData` shows the file byte at `peekAddr` combinationally.
- R11: After reset, W, the bank pointer, carry, negative, zero, `done` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| instr | input | 16 | Instruction word, captured with start |
| seedEn | input | 1 | Load W, bank pointer and carry from the seed inputs |
| seedW | input | 8 | Seed value for W |
| seedBsr | input | BSR_W | Seed value for the bank pointer |
| seedC | input | 1 | Seed value for carry |
| extWe | input | 1 | Side-port write strobe into the data file |
| extAddr | input | BSR_W+8 | Side-port write address |
| extData | input | 8 | Side-port write data |
| peekAddr | input | BSR_W+8 | Read address for the peek port |
| peekData | output | 8 | File byte at peekAddr |
| wOut | output | 8 | Working register W |
| bsrOut | output | BSR_W | Bank pointer |
| carry | output | 1 | Carry flag |
| neg | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |
| done | output | 1 | High during the write-back phase |
| illegal | output | 1 | One-cycle unrecognised-opcode pulse |

## Verification
A wrong decode or a corrupted effective address is visible on the peek port in the cycle after `done`. It shows either as a byte changed at the wrong bank or as an untouched decoy byte altered. A stale operand or carry latch gives a wrong W or a wrong file byte, together with mismatched carry, negative or zero flags, in that same cycle. A sequencing fault moves `done` away from the fourth cycle after `start`, or makes `illegal` coincide with a later `done`. Either is visible within five cycles of `start`.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int DATA_W  = 8;
  localparam int F_W     = 8;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_ROTL_NC = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_ROTR_C  = 6'b001100;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_Q1,
    PH_Q2,
    PH_Q3,
    PH_Q4
  } phase_t;

  typedef struct packed {
    logic idle;
    logic capture;
    logic latchDec;
    logic readOp;
    logic compute;
    logic writeBack;
  } strobe_t;
endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    legal,
  output strobe_t stb,
  output logic    done,
  output logic    illegal
);
  phase_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
    end else begin
      case (state)
        PH_IDLE: if (start) state <= PH_Q1;
        PH_Q1:   state <= legal ? PH_Q2 : PH_IDLE;
        PH_Q2:   state <= PH_Q3;
        PH_Q3:   state <= PH_Q4;
        PH_Q4:   state <= PH_IDLE;
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.idle      = (state == PH_IDLE);
    stb.capture   = (state == PH_IDLE) && start;
    stb.latchDec  = (state == PH_Q1) && legal;
    stb.readOp    = (state == PH_Q2);
    stb.compute   = (state == PH_Q3);
    stb.writeBack = (state == PH_Q4);
    done          = (state == PH_Q4);
    illegal       = (state == PH_Q1) && !legal;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> (!done && !illegal)); // R8
  AST_START_LEADS_Q1: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (done == 1'b0)); // R7
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int BSR_W = 4,
  localparam int ADDR_W = BSR_W + F_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [INSTR_W-1:0] instr,
  input  logic               seedEn,
  input  logic [DATA_W-1:0]  seedW,
  input  logic [BSR_W-1:0]   seedBsr,
  input  logic               seedC,
  input  logic               extWe,
  input  logic [ADDR_W-1:0]  extAddr,
  input  logic [DATA_W-1:0]  extData,
  input  logic [ADDR_W-1:0]  peekAddr,
  output logic [DATA_W-1:0]  peekData,
  output logic               legal,
  output logic [DATA_W-1:0]  wReg,
  output logic [BSR_W-1:0]   bsr,
  output logic               carry,
  output logic               neg,
  output logic               zero
);
  logic [DATA_W-1:0] fileMem [DEPTH];
  logic [INSTR_W-1:0] instrReg;
  logic [OPC_W-1:0]   opc;
  logic [F_W-1:0]     fAddr;
  logic               isLeft, dBit;
  logic [ADDR_W-1:0]  effAddr;
  logic [DATA_W-1:0]  operand, result, rotL, rotR;
  logic               newC;

  assign opc   = instrReg[INSTR_W-1 -: OPC_W];
  assign fAddr = instrReg[F_W-1:0];
  assign legal = (opc == OPC_ROTL_NC) || (opc == OPC_ROTR_C);

  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    assign rotL[(i + 1) % DATA_W] = operand[i];
    if (i == DATA_W - 1) begin : g_top
      assign rotR[i] = carry;
    end else begin : g_mid
      assign rotR[i] = operand[i + 1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrReg <= '0;
      isLeft   <= 1'b0;
      dBit     <= 1'b0;
      effAddr  <= '0;
      operand  <= '0;
      result   <= '0;
      newC     <= 1'b0;
      wReg     <= '0;
      bsr      <= '0;
      carry    <= 1'b0;
      neg      <= 1'b0;
      zero     <= 1'b0;
    end else begin
      if (stb.capture) instrReg <= instr;
      if (stb.latchDec) begin
        isLeft  <= (opc == OPC_ROTL_NC);
        dBit    <= instrReg[F_W+1];
        effAddr <= instrReg[F_W] ? {bsr, fAddr}
                                 : {{BSR_W{fAddr[F_W-1]}}, fAddr};
      end
      if (stb.readOp) operand <= fileMem[effAddr];
      if (stb.compute) begin
        result <= isLeft ? rotL : rotR;
        newC   <= isLeft ? carry : operand[0];
      end
      if (stb.writeBack) begin
        if (!dBit) wReg <= result;
        carry <= newC;
        neg   <= result[DATA_W-1];
        zero  <= (result == '0);
      end
      if (stb.idle && seedEn) begin
        wReg  <= seedW;
        bsr   <= seedBsr;
        carry <= seedC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.writeBack && dBit)
      fileMem[effAddr] <= result;
    else if (stb.idle && extWe)
      fileMem[extAddr] <= extData;
  end

  assign peekData = fileMem[peekAddr];

  AST_LEFT_HOLDS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeBack && isLeft) |=> (carry == $past(carry))); // R2
  AST_RIGHT_CARRY_LSB: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeBack && !isLeft) |=> (carry == $past(operand[0]))); // R3
  AST_W_HELD_FILE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeBack && dBit) |=> $stable(wReg)); // R4
  AST_BSR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idle |=> $stable(bsr)); // R10
  AST_INSTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idle |=> $stable(instrReg)); // R9
endmodule

// File: rtl/rot_exec_unit.sv
module rot_exec_unit
  import rot_pkg::*;
#(
  parameter int BSR_W = 4,
  localparam int ADDR_W = BSR_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instr,
  input  logic              seedEn,
  input  logic [7:0]        seedW,
  input  logic [BSR_W-1:0]  seedBsr,
  input  logic              seedC,
  input  logic              extWe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [7:0]        extData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [7:0]        peekData,
  output logic [7:0]        wOut,
  output logic [BSR_W-1:0]  bsrOut,
  output logic              carry,
  output logic              neg,
  output logic              zero,
  output logic              done,
  output logic              illegal
);
  strobe_t stb;
  logic    legal;

  rot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .legal(legal),
    .stb(stb), .done(done), .illegal(illegal)
  );

  rot_datapath #(.BSR_W(BSR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .instr(instr),
    .seedEn(seedEn), .seedW(seedW), .seedBsr(seedBsr), .seedC(seedC),
    .extWe(extWe), .extAddr(extAddr), .extData(extData),
    .peekAddr(peekAddr), .peekData(peekData), .legal(legal),
    .wReg(wOut), .bsr(bsrOut), .carry(carry), .neg(neg), .zero(zero)
  );
endmodule

// File: tb/sim_rot_exec_unit.sv
`timescale 1ns/1ps
module sim_rot_exec_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] instr = '0;
  logic seedEn = 1'b0;
  logic [7:0] seedW = '0;
  logic [3:0] seedBsr = '0;
  logic seedC = 1'b0;
  logic extWe = 1'b0;
  logic [11:0] extAddr = '0;
  logic [7:0] extData = '0;
  logic [11:0] peekAddr = '0;
  logic [7:0] peekData, wOut;
  logic [3:0] bsrOut;
  logic carry, neg, zero, done, illegal;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rot_exec_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .seedEn(seedEn), .seedW(seedW), .seedBsr(seedBsr), .seedC(seedC),
    .extWe(extWe), .extAddr(extAddr), .extData(extData),
    .peekAddr(peekAddr), .peekData(peekData), .wOut(wOut), .bsrOut(bsrOut),
    .carry(carry), .neg(neg), .zero(zero), .done(done), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seed(input logic [7:0] w, input logic [3:0] b, input logic c);
    @(negedge clk);
    seedEn = 1'b1; seedW = w; seedBsr = b; seedC = c;
    @(negedge clk);
    seedEn = 1'b0;
  endtask

  task automatic fileWrite(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    extWe = 1'b1; extAddr = a; extData = v;
    @(negedge clk);
    extWe = 1'b0;
  endtask

  function automatic logic [7:0] peekAt(input logic [11:0] a);
    return 8'h00;
  endfunction

  // Runs one instruction; returns the cycle index of done (-1 if none) and
  // whether illegal was seen in the first cycle after start.
  task automatic runOp(input logic [15:0] ins, input bit intrude,
                       output int doneAt, output bit sawIll, output int illCount);
    @(negedge clk);
    start = 1'b1; instr = ins;
    @(negedge clk);
    start = 1'b0;
    sawIll = illegal;
    illCount = illegal ? 1 : 0;
    doneAt = -1;
    if (done) doneAt = 1;
    for (int k = 2; k <= 6; k++) begin
      if (intrude && k == 2) begin
        start = 1'b1; instr = 16'h4412;
      end
      @(negedge clk);
      start = 1'b0;
      if (done) doneAt = k;
      if (illegal) illCount++;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dAt, ic;
    bit sIll;
    logic [7:0] expRes, wInit;
    logic expC;
    logic [11:0] addr, decoy;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(wOut == 8'h00, "R11 W", wOut, 0);
    check(bsrOut == 4'h0, "R11 bsr", bsrOut, 0);
    check({carry, neg, zero} == 3'b000, "R11 flags", {carry, neg, zero}, 0);
    check({done, illegal} == 2'b00, "R11 done/illegal", {done, illegal}, 0);

    // R1 worked example: 0xAB -> 0x57, file destination, a=1 bank 3
    fileWrite(12'h342, 8'hAB);
    seed(8'h11, 4'h3, 1'b1);
    runOp(16'h4742, 1'b0, dAt, sIll, ic);
    peekAddr = 12'h342; #1;
    check(peekData == 8'h57, "R1 example", peekData, 8'h57);
    check(carry == 1'b1, "R2 example carry kept", carry, 1);
    check(dAt == 4, "R7 done cycle", dAt, 4);

    // R3 worked example: 0xE6, C=0, d=0 -> W=0x73, C=0, file unchanged
    fileWrite(12'h342, 8'hE6);
    seed(8'h00, 4'h3, 1'b0);
    runOp(16'h3142, 1'b0, dAt, sIll, ic);
    peekAddr = 12'h342; #1;
    check(wOut == 8'h73, "R3 example W", wOut, 8'h73);
    check(carry == 1'b0, "R3 example C", carry, 0);
    check(peekData == 8'hE6, "R4 example file kept", peekData, 8'hE6);

    // Exhaustive sweep: operand x carry x opcode x destination (R1..R4, R7)
    for (int op = 0; op < 2; op++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 2; c++) begin
          for (int v = 0; v < 256; v++) begin
            wInit = 8'(v) ^ 8'h5A;
            fileWrite(12'h342, 8'(v));
            seed(wInit, 4'h3, c[0]);
            runOp({(op == 0) ? 6'b010001 : 6'b001100, d[0], 1'b1, 8'h42},
                  1'b0, dAt, sIll, ic);
            if (op == 0) begin
              expRes = {8'(v) << 1} | 8'(v >> 7);
              expC = c[0];
            end else begin
              expRes = {c[0], 7'(v >> 1)};
              expC = v[0];
            end
            peekAddr = 12'h342; #1;
            if (d == 1) begin
              check(peekData == expRes, (op == 0) ? "R1 rotl file" : "R3 rotr file", peekData, expRes);
              check(wOut == wInit, "R4 W kept", wOut, wInit);
            end else begin
              check(wOut == expRes, (op == 0) ? "R1 rotl W" : "R3 rotr W", wOut, expRes);
              check(peekData == 8'(v), "R4 file kept", peekData, v);
            end
            check(carry == expC, (op == 0) ? "R2 carry kept" : "R3 carry", carry, expC);
            check(neg == expRes[7] && zero == (expRes == 8'h00), "R2 N/Z",
                  {neg, zero}, {expRes[7], expRes == 8'h00});
            check(dAt == 4 && !sIll, "R7 done timing", dAt, 4);
          end
        end
      end
    end

    // Address sweep: access bank (R6) and banked (R5)
    for (int f = 0; f < 256; f += 5) begin
      for (int a = 0; a < 2; a++) begin
        if (a == 1) addr = {4'h7, 8'(f)};
        else addr = {(f >= 128) ? 4'hF : 4'h0, 8'(f)};
        decoy = (a == 1) ? {4'h0, 8'(f)} : {4'h7, 8'(f)};
        fileWrite(decoy, 8'h00);
        fileWrite(addr, 8'h81);
        seed(8'h00, 4'h7, 1'b0);
        runOp({6'b010001, 1'b1, a[0], 8'(f)}, 1'b0, dAt, sIll, ic);
        peekAddr = addr; #1;
        check(peekData == 8'h03, (a == 1) ? "R5 banked target" : "R6 access target", peekData, 8'h03);
        peekAddr = decoy; #1;
        check(peekData == 8'h00, (a == 1) ? "R5 decoy untouched" : "R6 bsr ignored", peekData, 0);
      end
    end

    // Illegal opcode sweep (R8)
    for (int o = 0; o < 64; o++) begin
      if (o != 6'b010001 && o != 6'b001100) begin
        fileWrite(12'h342, 8'h96);
        seed(8'h3C, 4'h3, 1'b1);
        runOp({6'(o), 2'b11, 8'h42}, 1'b0, dAt, sIll, ic);
        peekAddr = 12'h342; #1;
        check(sIll && ic == 1, "R8 illegal pulse", ic, 1);
        check(dAt == -1, "R8 no done", dAt, -1);
        check(wOut == 8'h3C && carry == 1'b1 && bsrOut == 4'h3 && peekData == 8'h96,
              "R8 state kept", {wOut, peekData}, 16'h3C96);
      end
    end

    // R9: start pulsed mid-instruction
    fileWrite(12'h342, 8'h01);
    seed(8'h00, 4'h3, 1'b0);
    runOp(16'h4742, 1'b1, dAt, sIll, ic);
    peekAddr = 12'h342; #1;
    check(peekData == 8'h02 && dAt == 4, "R9 busy start ignored", peekData, 8'h02);
    @(negedge clk);
    check(!done && !illegal, "R9 no second run", {done, illegal}, 0);

    // R10: side port and seed; peek sees write
    fileWrite(12'hABC, 8'h5E);
    peekAddr = 12'hABC; #1;
    check(peekData == 8'h5E, "R10 side write", peekData, 8'h5E);
    seed(8'hC3, 4'h9, 1'b1);
    check(wOut == 8'hC3 && bsrOut == 4'h9 && carry, "R10 seed", {wOut, bsrOut}, 12'hC39);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule